// File: doc/BRIEF.md
# Controller Clock Divider with Ratio Table and External Bypass

This block derives a controller clock from a fast source clock. A 3-bit code picks one of eight division ratios from a fixed table. The table is not uniform: it includes 6 and 24 alongside the powers of two. The divided waveform is produced as a registered level, together with a one-cycle tick that marks the first source cycle of every output period.

A divider-reset input parks the counter. Software raises it before it loads a new ratio and lowers it afterwards. A clock-enable input gates everything that leaves the block. A bypass select swaps the divided waveform for a clock arriving from outside the block.

The settings that are in force are returned on readback outputs:
- the ratio code the counter is actually using;
- the registered enable;
- the registered bypass.

If the ratio code changes while the divider runs, the current period finishes at the old ratio. The new code is picked up at the next period boundary, so no shortened pulse is produced. Software normally chooses the smallest code whose output lands between 150 and 300 MHz, so a 150 MHz source uses divide-by-1.

Top module: `ctlclk_divider`

## Requirements
- R1: While and right after `rst_n` is low at a clock edge, `ctl_clk`, `ctl_tick`, `rb_sel`, `rb_en` and `rb_byp` are all 0.
- R2: Code c on `ratio_sel` selects a period of N source cycles, where codes 0..7 map to N = 1, 2, 4, 6, 8, 16, 24, 32. With enable on and bypass off, `ctl_tick` is high once every N cycles.
- R3: Within each period, `ctl_clk` is high for the first floor(N/2) cycles and low for the rest. Cycle 0 is the cycle in which `ctl_tick` is high. For N = 1, `ctl_clk` stays high.
- R4: While `div_rst` is high, `ctl_tick` and the divided `ctl_clk` are 0 from the next cycle on. After the edge at which `div_rst` is seen low, the next cycle is cycle 0 of a period.
- R5: When `clk_en` was 0 at the last edge, `ctl_clk` and `ctl_tick` are 0. This holds in both divided and bypass modes.
- R6: When `byp_sel` was 1 at the last edge and `clk_en` was 1, `ctl_clk` follows `ext_clk` and `ctl_tick` stays 0.
- R7: A change of `ratio_sel` while the divider runs takes effect only after the last cycle of the current period, so that period keeps its old length.
- R8: `rb_en` and `rb_byp` equal the `clk_en` and `byp_sel` values seen at the previous edge.
- R9: An edge with `div_rst` high loads `ratio_sel` into the active code immediately; `rb_sel` shows it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_rst | input | 1 | Holds the divider counter in reset, active high |
| clk_en | input | 1 | Enables the controller clock outputs |
| ratio_sel | input | 3 | Ratio code, 0..7 selects 1,2,4,6,8,16,24,32 |
| byp_sel | input | 1 | 0 = divided clock, 1 = external clock |
| ext_clk | input | 1 | Externally supplied clock for bypass |
| ctl_clk | output | 1 | Gated controller clock |
| ctl_tick | output | 1 | One-cycle pulse at the start of each divided period |
| rb_sel | output | 3 | Ratio code currently in force |
| rb_en | output | 1 | Registered enable |
| rb_byp | output | 1 | Registered bypass select |

## Verification
The bench runs every table code and random ratio pairs, and checks the tick spacing and the high/low split in every cycle. A wrong table entry or an off-by-one terminal count would shift ticks. A wrong half-point would skew the duty, and a divide-by-1 that followed the general rule would drop to constant low.

The ratio is changed one cycle into a period. A design that switched immediately would cut that period short and emit a runt pulse.

Divider-reset release is checked for starting cleanly at cycle 0; a design that counted on release would skip the first high cycle. Enable and bypass are toggled at random to catch a tick leaking in bypass or an external clock passing while disabled.

// File: rtl/cdiv_pkg.sv
// Shared constants and the ratio table for the controller clock divider.
// Assumes a 3-bit code; the table is computed by a function, not stored.
package cdiv_pkg;
    localparam int SEL_W     = 3;
    localparam int MAX_RATIO = 32;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    // Map a ratio code to its division factor.
    function automatic int unsigned ratio_of(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 16;
            3'd6:    return 24;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/cdiv_ratio_lut.sv
// Decodes the active ratio code into the terminal count, the high-phase
// length and a divide-by-1 flag. Purely combinational.
module cdiv_ratio_lut #(
    parameter int SEL_W = cdiv_pkg::SEL_W,
    parameter int CNT_W = cdiv_pkg::CNT_W
) (
    input  logic [SEL_W-1:0] code,
    output logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] high_len,
    output logic             unity
);
    int unsigned ratio;

    // Look up the ratio and derive count limits from it.
    always_comb begin
        ratio    = cdiv_pkg::ratio_of(code);
        last_cnt = CNT_W'(ratio - 1);
        high_len = CNT_W'(ratio / 2);
        unity    = (ratio == 1);
    end
endmodule

// File: rtl/cdiv_counter.sv
// Period counter. It holds at zero during the divider reset and loads the
// requested code there. While running it wraps at the terminal count and
// only takes a new code at that wrap, so periods are never cut short.
module cdiv_counter #(
    parameter int SEL_W = cdiv_pkg::SEL_W,
    parameter int CNT_W = cdiv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_rst,
    input  logic [SEL_W-1:0] sel_req,
    input  logic [CNT_W-1:0] last_cnt,
    input  logic [CNT_W-1:0] high_len,
    input  logic             unity,
    output logic [SEL_W-1:0] act_sel,
    output logic             lvl,
    output logic             at_start
);
    logic [CNT_W-1:0] cnt;
    logic             hold;

    // Advance the counter, and switch ratio only at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_sel <= '0;
            hold    <= 1'b1;
        end else if (div_rst) begin
            cnt     <= '0;
            act_sel <= sel_req;
            hold    <= 1'b1;
        end else if (hold) begin
            hold    <= 1'b0;
        end else if (cnt == last_cnt) begin
            cnt     <= '0;
            act_sel <= sel_req;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    // Derive the divided level and the period-start marker from state.
    always_comb begin
        lvl      = !hold && (unity || (cnt < high_len));
        at_start = !hold && (cnt == '0);
    end
endmodule

// File: rtl/cdiv_settings.sv
// Registers the enable and bypass inputs. The registered copies drive
// the output gating and are also returned as readback.
module cdiv_settings (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic byp_sel,
    output logic en_q,
    output logic byp_q
);
    // Capture the enable and bypass selections each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            en_q  <= clk_en;
            byp_q <= byp_sel;
        end
    end
endmodule

// File: rtl/cdiv_out_stage.sv
// Selects the divided or external clock and gates both with the
// registered enable. The tick exists only in divided mode.
module cdiv_out_stage (
    input  logic en_q,
    input  logic byp_q,
    input  logic lvl,
    input  logic at_start,
    input  logic ext_clk,
    output logic ctl_clk,
    output logic ctl_tick
);
    // Clock source select and enable gating.
    always_comb begin
        ctl_clk  = en_q & (byp_q ? ext_clk : lvl);
        ctl_tick = en_q & ~byp_q & at_start;
    end
endmodule

// File: rtl/ctlclk_divider.sv
// Top of the controller clock divider. It joins the ratio decode, the
// period counter, the settings registers and the output stage. The
// inputs are assumed synchronous to clk, apart from ext_clk.
module ctlclk_divider #(
    parameter int SEL_W = cdiv_pkg::SEL_W,
    parameter int CNT_W = cdiv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_rst,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             byp_sel,
    input  logic             ext_clk,
    output logic             ctl_clk,
    output logic             ctl_tick,
    output logic [SEL_W-1:0] rb_sel,
    output logic             rb_en,
    output logic             rb_byp
);
    logic [SEL_W-1:0] act_sel;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] high_len;
    logic             unity;
    logic             lvl;
    logic             at_start;
    logic             en_q;
    logic             byp_q;

    cdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lut (
        .code(act_sel), .last_cnt(last_cnt), .high_len(high_len), .unity(unity)
    );

    cdiv_counter #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .sel_req(ratio_sel),
        .last_cnt(last_cnt), .high_len(high_len), .unity(unity),
        .act_sel(act_sel), .lvl(lvl), .at_start(at_start)
    );

    cdiv_settings u_set (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .byp_sel(byp_sel),
        .en_q(en_q), .byp_q(byp_q)
    );

    cdiv_out_stage u_out (
        .en_q(en_q), .byp_q(byp_q), .lvl(lvl), .at_start(at_start),
        .ext_clk(ext_clk), .ctl_clk(ctl_clk), .ctl_tick(ctl_tick)
    );

    // Readback of the settings in force.
    always_comb begin
        rb_sel = act_sel;
        rb_en  = en_q;
        rb_byp = byp_q;
    end
endmodule

// File: rtl/ctlclk_divider_chk.sv
// Property checker for the controller clock divider, attached by bind.
module ctlclk_divider_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_rst,
    input logic             clk_en,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             byp_sel,
    input logic             ctl_clk,
    input logic             ctl_tick,
    input logic [SEL_W-1:0] rb_sel,
    input logic             rb_en,
    input logic             rb_byp
);
    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rst && !byp_sel) |=> (!ctl_tick && !ctl_clk));

    // R5
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (!ctl_tick && !ctl_clk));

    // R6
    byp_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_sel |=> !ctl_tick);

    // R8
    rb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rb_en == $past(clk_en) && rb_byp == $past(byp_sel)));

    // R9
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> (rb_sel == $past(ratio_sel)));

    // R7
    sel_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rb_sel) && !$past(div_rst) && rb_en && !rb_byp) |-> ctl_tick);
endmodule

bind ctlclk_divider ctlclk_divider_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .clk_en(clk_en),
    .ratio_sel(ratio_sel), .byp_sel(byp_sel), .ctl_clk(ctl_clk),
    .ctl_tick(ctl_tick), .rb_sel(rb_sel), .rb_en(rb_en), .rb_byp(rb_byp)
);

// File: tb/ctlclk_divider_test.sv
module ctlclk_divider_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_rst = 1'b0;
    logic       clk_en = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       byp_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ctl_clk, ctl_tick, rb_en, rb_byp;
    logic [2:0] rb_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlclk_divider uut (
        .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .clk_en(clk_en),
        .ratio_sel(ratio_sel), .byp_sel(byp_sel), .ext_clk(ext_clk),
        .ctl_clk(ctl_clk), .ctl_tick(ctl_tick), .rb_sel(rb_sel),
        .rb_en(rb_en), .rb_byp(rb_byp)
    );

    function automatic int ratio(input int code);
        int tbl [8] = '{1, 2, 4, 6, 8, 16, 24, 32};
        return tbl[code];
    endfunction

    function automatic int exp_lvl(input int n, input int k);
        if (n == 1) return 1;
        return ((k % n) < (n / 2)) ? 1 : 0;
    endfunction

    function automatic int exp_tick(input int n, input int k);
        return ((k % n) == 0) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Load a code through divider reset, then check three periods.
    task automatic run_ratio(input int code);
        int n;
        n = ratio(code);
        @(negedge clk);
        div_rst = 1'b1; ratio_sel = 3'(code);
        @(negedge clk);
        chk("R4 clk held", int'(ctl_clk), 0);
        chk("R4 tick held", int'(ctl_tick), 0);
        chk("R9 rb_sel load", int'(rb_sel), code);
        div_rst = 1'b0;
        for (int k = 0; k < 3 * n; k++) begin
            @(negedge clk);
            chk("R2 tick", int'(ctl_tick), exp_tick(n, k));
            chk("R3 level", int'(ctl_clk), exp_lvl(n, k));
        end
    endtask

    // Change ratio one cycle into a period; old period must complete.
    task automatic run_change(input int c_old, input int c_new);
        int no, nn, s;
        no = ratio(c_old); nn = ratio(c_new);
        s = (no == 1) ? 2 : no;
        @(negedge clk);
        div_rst = 1'b1; ratio_sel = 3'(c_old);
        @(negedge clk);
        div_rst = 1'b0;
        for (int k = 0; k < s + 2 * nn; k++) begin
            @(negedge clk);
            if (k < s) begin
                chk("R7 old tick", int'(ctl_tick), exp_tick(no, k));
                chk("R7 old level", int'(ctl_clk), exp_lvl(no, k));
                chk("R7 old sel", int'(rb_sel), c_old);
            end else begin
                chk("R7 new tick", int'(ctl_tick), exp_tick(nn, k - s));
                chk("R7 new level", int'(ctl_clk), exp_lvl(nn, k - s));
                chk("R7 new sel", int'(rb_sel), c_new);
            end
            if (k == 1) ratio_sel = 3'(c_new);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7391);
        repeat (3) @(negedge clk);
        chk("R1 clk", int'(ctl_clk), 0);
        chk("R1 tick", int'(ctl_tick), 0);
        chk("R1 rb_sel", int'(rb_sel), 0);
        chk("R1 rb_en", int'(rb_en), 0);
        chk("R1 rb_byp", int'(rb_byp), 0);
        clk_en = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        for (int c = 0; c < 8; c++) run_ratio(c);
        for (int i = 0; i < 12; i++) run_change(int'($urandom % 8), int'($urandom % 8));
        run_change(0, 7);
        run_change(7, 0);

        // Enable off gates everything.
        run_ratio(2);
        clk_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R5 clk off", int'(ctl_clk), 0);
            chk("R5 tick off", int'(ctl_tick), 0);
        end
        clk_en = 1'b1;

        // Bypass follows the external clock.
        byp_sel = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            ext_clk = k[0];
            #1;
            chk("R6 ext follow", int'(ctl_clk), k[0] ? 1 : 0);
            chk("R6 no tick", int'(ctl_tick), 0);
            @(negedge clk);
        end

        // Random enable, bypass and external level.
        for (int i = 0; i < 60; i++) begin
            logic e, b, x;
            e = 1'($urandom); b = 1'($urandom); x = 1'($urandom);
            clk_en = e; byp_sel = b;
            @(negedge clk);
            ext_clk = x;
            #1;
            chk("R8 rb_en", int'(rb_en), int'(e));
            chk("R8 rb_byp", int'(rb_byp), int'(b));
            if (!e) chk("R5 gated", int'(ctl_clk), 0);
            if (b) chk("R6 tick", int'(ctl_tick), 0);
            if (b && e) chk("R6 ext", int'(ctl_clk), int'(x));
        end

        // Reset returns to idle state.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset rb_sel", int'(rb_sel), 0);
        chk("R1 reset clk", int'(ctl_clk), 0);
        chk("R1 reset rb_en", int'(rb_en), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule